// File: doc/BRIEF.md
# Folded Word Memory with Column Selection

A synchronous single-port memory holding 2048 words of 16 bits. Inside, the words are kept as 256 wide lines of 128 bits, eight words to a line. An incoming word address is split into a line (row) index and a word-within-line (column group) index. A one-hot row decoder selects the line. On a read the whole line is fetched into a register, and sixteen 8:1 column multiplexers pick the addressed word out of it. On a write only the sixteen columns of the addressed word are changed, under a column mask.

Each clock cycle carries exactly one operation, a read or a write, and a new one is accepted every cycle. The memory never applies back-pressure, so the interface has no valid or ready pins. Read data appears one cycle after the address. In a write cycle, the read path returns the word as it was before that write.

Top module: `fold_mem`

## Requirements
- R1: Read data for the address presented at clock edge N is visible on `rd_data` after edge N and holds until edge N+1, giving one cycle of latency.
- R2: A word written to any address in 0..2047 reads back unchanged until that address is written again.
- R3: For every cycle out of reset, the row decoder drives exactly one of its 256 row-select lines.
- R4: For every cycle out of reset, the column-group decoder drives exactly one of its 8 group-select lines.
- R5: A write changes only the addressed word. The other seven words in the same line, which share `addr[10:3]`, keep their values.
- R6: In a write cycle, `rd_data` after that edge shows the data the address held before the write.
- R7: While `rst_n` is low, `rd_data` is 0.
- R8: `addr[10:3]` is the line index and `addr[2:0]` the word within the line. The extreme addresses 0 and 2047 and the words at both ends of a line are stored independently.
- R9: Two reads in a row of the same address with no write between them return the same data.
- R10: Any mix of reads and writes on consecutive cycles is served without a stall, each cycle's result matching a word-accurate memory model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the read path |
| wr_en | input | 1 | 1 = write this cycle, 0 = read |
| addr | input | 11 | Word address: [10:3] line, [2:0] word in line |
| wr_data | input | 16 | Word to store when `wr_en` is 1 |
| rd_data | output | 16 | Registered read word, one cycle after `addr` |

## Verification
The hardest case to reach from the ports is a write that must leave its seven line neighbours untouched. A broken column mask only shows up if the neighbours hold distinct, known values and are read after the write. The stimulus therefore first fills the whole memory with an address-dependent pattern. It then overwrites a single word in a chosen line and reads all eight words of that line back. Read-during-write is reached by presenting the same address as a read and then as a write on back-to-back cycles, while a model tracks the old contents.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned ROW_WORDS = 8;
  localparam int unsigned ROWS      = 256;
endpackage

// File: rtl/fold_onehot_dec.sv
module fold_onehot_dec #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  sel
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel[i] = (idx == IW'(i));
  end
endmodule

// File: rtl/fold_line_store.sv
module fold_line_store #(
  parameter int unsigned ROWS   = 256,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [RW-1:0]     row_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [LINE_W-1:0] wr_mask,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] lines [ROWS];

  // Masked update of the selected line only.
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr_en && row_sel[r])
        lines[r] <= (lines[r] & ~wr_mask) | (wr_line & wr_mask);
    end
  end

  // Line fetch sees the contents before this cycle's write.
  always_ff @(posedge clk) begin
    if (!rst_n) rd_line <= '0;
    else        rd_line <= lines[row_idx];
  end
endmodule

// File: rtl/fold_col_mux.sv
module fold_col_mux #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ROW_WORDS = 8,
  localparam int unsigned LINE_W = WORD_W * ROW_WORDS,
  localparam int unsigned CW     = $clog2(ROW_WORDS)
) (
  input  logic [LINE_W-1:0] line,
  input  logic [CW-1:0]     col_idx,
  output logic [WORD_W-1:0] word
);
  // Bit b of every word sits in the adjacent group b*ROW_WORDS .. +ROW_WORDS-1.
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    logic [ROW_WORDS-1:0] grp;
    assign grp     = line[b*ROW_WORDS +: ROW_WORDS];
    assign word[b] = grp[col_idx];
  end
endmodule

// File: rtl/fold_mem.sv
module fold_mem
  import fold_mem_pkg::*;
#(
  parameter int unsigned P_WORD_W    = WORD_W,
  parameter int unsigned P_ROW_WORDS = ROW_WORDS,
  parameter int unsigned P_ROWS      = ROWS,
  localparam int unsigned LINE_W = P_WORD_W * P_ROW_WORDS,
  localparam int unsigned CW     = $clog2(P_ROW_WORDS),
  localparam int unsigned RW     = $clog2(P_ROWS),
  localparam int unsigned AW     = RW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [P_WORD_W-1:0] wr_data,
  output logic [P_WORD_W-1:0] rd_data
);
  logic [RW-1:0]          row_idx;
  logic [CW-1:0]          col_idx;
  logic [CW-1:0]          col_q;
  logic [P_ROWS-1:0]      row_sel;
  logic [P_ROW_WORDS-1:0] col_sel;
  logic [LINE_W-1:0]      wr_line;
  logic [LINE_W-1:0]      wr_mask;
  logic [LINE_W-1:0]      rd_line;

  assign row_idx = addr[AW-1:CW];
  assign col_idx = addr[CW-1:0];

  fold_onehot_dec #(.N(P_ROWS)) u_row_dec (.idx(row_idx), .sel(row_sel));
  fold_onehot_dec #(.N(P_ROW_WORDS)) u_col_dec (.idx(col_idx), .sel(col_sel));

  // Spread the word over its columns and build the column write mask.
  for (genvar b = 0; b < P_WORD_W; b++) begin : g_spread
    for (genvar c = 0; c < P_ROW_WORDS; c++) begin : g_grp
      assign wr_line[b*P_ROW_WORDS + c] = wr_data[b];
      assign wr_mask[b*P_ROW_WORDS + c] = col_sel[c];
    end
  end

  fold_line_store #(.ROWS(P_ROWS), .LINE_W(LINE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .row_sel (row_sel),
    .row_idx (row_idx),
    .wr_line (wr_line),
    .wr_mask (wr_mask),
    .rd_line (rd_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_idx;
  end

  fold_col_mux #(.WORD_W(P_WORD_W), .ROW_WORDS(P_ROW_WORDS)) u_col_mux (
    .line    (rd_line),
    .col_idx (col_q),
    .word    (rd_data)
  );
endmodule

// File: rtl/fold_mem_chk.sv
module fold_mem_chk #(
  parameter int unsigned AW     = 11,
  parameter int unsigned WW     = 16,
  parameter int unsigned NROW   = 256,
  parameter int unsigned NCOL   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [WW-1:0]   wr_data,
  input logic [WW-1:0]   rd_data,
  input logic [NROW-1:0] row_sel,
  input logic [NCOL-1:0] col_sel
);
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (!rst_n)         live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  p_row_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  p_col_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_sel) == 1);

  p_reset_zero_r7: assert property (@(posedge clk)
    (live == 2'd0 && !rst_n && !$isunknown(rd_data)) |-> rd_data == '0);

  p_old_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && wr_en && !$past(wr_en) && addr == $past(addr)) |=> $stable(rd_data));

  p_reread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && !wr_en && !$past(wr_en) && addr == $past(addr)) |=> $stable(rd_data));

  p_write_then_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 2'd3 && !wr_en && $past(wr_en) && addr == $past(addr)) |=> rd_data == $past(wr_data, 2));
endmodule

bind fold_mem fold_mem_chk #(.AW(AW), .WW(P_WORD_W), .NROW(P_ROWS), .NCOL(P_ROW_WORDS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .row_sel (row_sel),
  .col_sel (col_sel)
);

// File: tb/fold_mem_bench.sv
`timescale 1ns/1ps
module fold_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [15:0] model [2048];
  bit          known [2048];
  string       tag = "R7";

  always #2 clk = ~clk;

  fold_mem u_fold_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string why);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): got %h expected %h", tag, why, got, exp);
    end
  endtask

  // One operation: drive at negedge, sample 1 ns after the capturing edge.
  task automatic op(input bit we, input int a, input logic [15:0] d);
    logic [15:0] exp;
    bit          have;
    @(negedge clk);
    wr_en = we; addr = 11'(a); wr_data = d;
    have = known[a];
    exp  = model[a];
    if (we) begin model[a] = d; known[a] = 1'b1; end
    @(posedge clk); #1;
    if (have) check(rd_data, exp, $sformatf("addr %0d", a));
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503) ^ 16'h5a3c);
  endfunction

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;
    // R7: reset state
    repeat (3) @(posedge clk);
    #1 check(rd_data, 16'h0, "reset");
    @(negedge clk) check(rd_data, 16'h0, "reset held");
    rst_n = 1'b1;

    // R2 / R10: fill every word, writes back to back
    tag = "R2";
    for (int a = 0; a < 2048; a++) op(1'b1, a, pat(a));
    // R1 / R2: read all back, one per cycle
    tag = "R1";
    for (int a = 0; a < 2048; a++) op(1'b0, a, 16'h0);

    // R5: overwrite one word of line 17, then read the whole line
    tag = "R5";
    op(1'b1, 17*8 + 3, 16'hbeef);
    for (int c = 0; c < 8; c++) op(1'b0, 17*8 + c, 16'h0);
    op(1'b1, 17*8 + 0, 16'h1234);
    op(1'b1, 17*8 + 7, 16'h8765);
    for (int c = 0; c < 8; c++) op(1'b0, 17*8 + c, 16'h0);

    // R6: read then write same address; write cycle returns old data
    tag = "R6";
    op(1'b0, 500, 16'h0);
    op(1'b1, 500, 16'hc0de);
    op(1'b1, 500, 16'h0f0f);
    op(1'b0, 500, 16'h0);

    // R8: extreme addresses and same word in neighbouring lines
    tag = "R8";
    op(1'b1, 0, 16'hffff);
    op(1'b1, 2047, 16'h0001);
    op(1'b1, 8, 16'haaaa);
    op(1'b0, 0, 16'h0);
    op(1'b0, 2047, 16'h0);
    op(1'b0, 8, 16'h0);
    op(1'b0, 2040, 16'h0);

    // R9: repeated reads
    tag = "R9";
    for (int k = 0; k < 4; k++) op(1'b0, 1234, 16'h0);

    // R10: mixed traffic, kept on few lines to force collisions
    tag = "R10";
    for (int k = 0; k < 600; k++) begin
      int a;
      a = int'({$urandom_range(3) * 85, 3'(k)}) ^ int'($urandom_range(7));
      op(bit'($urandom_range(1)), a & 2047, 16'($urandom));
    end

    @(negedge clk);
    wr_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule